// File: doc/BRIEF.md
# Dual-Output Waveform Timer

An 8-bit counter is driven by a programmable clock divider and produces two waveform pins. The TOP value sets the length of the counting cycle. Output A toggles each time the counter turns at TOP, so it is always a 50% square wave. Output B is a pulse-width output whose duty comes from a second compare value. Three counting modes are available: clear-at-TOP with output A toggling, single-slope fast PWM, and dual-slope (up/down) phase-correct PWM.

The TOP and compare inputs are sampled into shadow registers only at a period boundary. Software-style updates can therefore change them at any time without cutting a period short or producing a runt pulse. The block is meant for generating fixed tones and noise-shaping clocks from a fast system clock.

Top module: `dual_wave_timer`

## Requirements
- R1: While reset is asserted, both wave outputs are low. After release the counter starts from zero and counts upward.
- R2: The divider select works as follows. Code 0 stops the counter, and both outputs then hold their levels. Codes 1 to 7 advance the counter once every 1, 8, 32, 64, 128, 256 and 1024 clock cycles, in that order.
- R3: Mode code 0 is clear-at-TOP, and code 3 behaves the same way. The counter runs 0..TOP and output A toggles on every TOP match, which gives a period of 2·(TOP+1)·div cycles. Output B stays low.
- R4: Mode code 1 is fast PWM. The counter runs 0..TOP, and output A is a 50% square wave with a period of 2·(TOP+1)·div cycles.
- R5: In fast PWM, output B has a period of (TOP+1)·div cycles. It is high for (min(CMP,TOP)+1)·div cycles of each period, starting at counter zero.
- R6: Mode code 2 is phase-correct. For TOP ≥ 1 the counter runs 0 up to TOP and back down, and output A toggles at each turn at TOP, which gives a period of 4·TOP·div cycles.
- R7: In phase-correct mode, output B has a period of 2·TOP·div cycles. It is high for 2·min(CMP,TOP)·div cycles, because it clears on the up-count match and sets on the down-count match. For example, TOP=180, CMP=50 and divide-by-64 give a B period of 23040 cycles with 6400 cycles high.
- R8: A new TOP or CMP value takes effect only at the next period boundary: the wrap in modes 0, 1 and 3, and the bottom of the count in mode 2.
- R9: Both outputs change only on a divided tick.
- R10: In modes 0, 1 and 3, the counter never exceeds the active TOP once a nonzero TOP is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Counting mode: 0 clear-at-TOP, 1 fast PWM, 2 phase-correct, 3 same as 0 |
| pre_sel | input | 3 | Divider select: 0 stop, 1..7 = /1,/8,/32,/64,/128,/256,/1024 |
| top_val | input | 8 | TOP value, shadowed at the period boundary |
| cmpb_val | input | 8 | Output B compare value, shadowed at the period boundary |
| wave_a | output | 1 | 50% square wave toggled at TOP |
| wave_b | output | 1 | Pulse-width output |

## Verification
The shadow reload and the TOP wrap land on the same tick. On that tick, output B's next level must already use the newly loaded compare value, while the period in progress must still finish under the old values. The bench waits for B's rising edge, changes TOP and CMP in the very next cycle, and judges the two high/low runs that follow: the first must match the old settings and the second the new ones. The compare-equal-TOP case also puts the A toggle and B's level change on one tick; the duty sweeps that include CMP = TOP and CMP > TOP judge it.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    MODE_CLR   = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_PHASE = 2'd2,
    MODE_ALT   = 2'd3
  } wave_mode_e;

  localparam int PRE_W   = 10;
  localparam int SEL_W   = 3;

  // log2 of the division ratio for each select code
  function automatic int div_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << div_shift(sel);
    return PRE_W'(one_hot - 1'b1);
  endfunction

endpackage

// File: rtl/dwt_prescaler.sv
module dwt_prescaler
  import dwt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    pre_d = pre_q + 1'b1;
    mask  = div_mask(sel);
    tick  = (sel != '0) && (&(pre_q | ~mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2: a stopped divider never ticks; divide-by-one ticks every cycle
  a_r2_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |-> !tick);
  a_r2_div1_every: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd1) |-> tick);

endmodule

// File: rtl/dwt_counter.sv
module dwt_counter
  import dwt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wave_mode_e       mode,
  input  logic [CNT_W-1:0] top_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             dir_dn_nxt,
  output logic [CNT_W-1:0] cmp_use,
  output logic             top_turn
);

  logic [CNT_W-1:0] cnt_q, top_q, cmp_q, top_use;
  logic             dir_dn_q;
  logic             is_phase, load;

  always_comb begin
    is_phase = (mode == MODE_PHASE);
    load     = is_phase ? (cnt_q == '0) : (cnt_q == top_q);
    top_use  = load ? top_in : top_q;
    cmp_use  = load ? cmp_in : cmp_q;
    if (is_phase) begin
      cnt_nxt = dir_dn_q ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
      if (cnt_nxt == '0)           dir_dn_nxt = 1'b0;
      else if (cnt_nxt >= top_use) dir_dn_nxt = 1'b1;
      else                         dir_dn_nxt = dir_dn_q;
      top_turn = !dir_dn_q && dir_dn_nxt;
    end else begin
      cnt_nxt    = (cnt_q == top_q) ? '0 : (cnt_q + 1'b1);
      dir_dn_nxt = 1'b0;
      top_turn   = (cnt_q == top_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_dn_q <= 1'b0;
      top_q    <= '0;
      cmp_q    <= '0;
    end else if (tick) begin
      cnt_q    <= cnt_nxt;
      dir_dn_q <= dir_dn_nxt;
      if (load) begin
        top_q <= top_in;
        cmp_q <= cmp_in;
      end
    end
  end

  // R10: single-slope modes stay within the active TOP
  a_r10_cnt_le_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_phase && top_q != '0) |-> (cnt_q <= top_q));
  // R6: the dual-slope count always leaves zero heading upward
  a_r6_bottom_up: assert property (@(posedge clk) disable iff (!rst_n)
    (is_phase && cnt_q == '0) |-> !dir_dn_q);

endmodule

// File: rtl/dwt_wavegen.sv
module dwt_wavegen
  import dwt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wave_mode_e       mode,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             dir_dn_nxt,
  input  logic [CNT_W-1:0] cmp_use,
  input  logic             top_turn,
  output logic             wave_a,
  output logic             wave_b
);

  logic a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = a_q ^ top_turn;
    case (mode)
      MODE_FAST:  b_d = (cnt_nxt <= cmp_use);
      MODE_PHASE: b_d = dir_dn_nxt ? (cnt_nxt <= cmp_use) : (cnt_nxt < cmp_use);
      default:    b_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else if (tick) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign wave_a = a_q;
  assign wave_b = b_q;

  // R9: without a divided tick both pins hold
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(wave_a) && $stable(wave_b)));
  // R3: clear-at-TOP modes drive B low after any tick
  a_r3_b_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (mode == MODE_CLR || mode == MODE_ALT)) |=> !wave_b);

endmodule

// File: rtl/dual_wave_timer.sv
module dual_wave_timer
  import dwt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [2:0]       pre_sel,
  input  logic [CNT_W-1:0] top_val,
  input  logic [CNT_W-1:0] cmpb_val,
  output logic             wave_a,
  output logic             wave_b
);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             tick;
  wave_mode_e       mode;
  logic [CNT_W-1:0] cnt_nxt, cmp_use;
  logic             dir_dn_nxt, top_turn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];
  assign mode      = wave_mode_e'(mode_sel);

  dwt_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel   (pre_sel),
    .tick  (tick)
  );

  dwt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .mode       (mode),
    .top_in     (top_val),
    .cmp_in     (cmpb_val),
    .cnt_nxt    (cnt_nxt),
    .dir_dn_nxt (dir_dn_nxt),
    .cmp_use    (cmp_use),
    .top_turn   (top_turn)
  );

  dwt_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .mode       (mode),
    .cnt_nxt    (cnt_nxt),
    .dir_dn_nxt (dir_dn_nxt),
    .cmp_use    (cmp_use),
    .top_turn   (top_turn),
    .wave_a     (wave_a),
    .wave_b     (wave_b)
  );

  // R1: outputs are low while reset is held
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_int_n |-> (!wave_a && !wave_b));

endmodule

// File: tb/sim_dual_wave_timer.sv
module sim_dual_wave_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic [2:0] pre_sel;
  logic [7:0] top_val, cmpb_val;
  logic       wave_a, wave_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  dual_wave_timer u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .pre_sel  (pre_sel),
    .top_val  (top_val),
    .cmpb_val (cmpb_val),
    .wave_a   (wave_a),
    .wave_b   (wave_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int divisor(input int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 32;
      4: return 64;
      5: return 128;
      6: return 256;
      7: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic start(input int md, input int sel, input int top, input int cmp);
    @(negedge clk);
    rst_n    = 1'b0;
    mode_sel = 2'(md);
    pre_sel  = 3'(sel);
    top_val  = 8'(top);
    cmpb_val = 8'(cmp);
    repeat (3) @(negedge clk);
    check(wave_a == 1'b0 && wave_b == 1'b0, "R1 reset low", {wave_a, wave_b}, 0);
    rst_n = 1'b1;
  endtask

  // Measures one full A period after settling, and compares the counts with the formulas
  task automatic run_cfg(input int md, input int sel, input int top, input int cmp, input string tag);
    int div, aper, bper, bhi, ahi_n, bhi_n, edges;
    logic prev_a;
    div = divisor(sel);
    if (md == 2) begin
      bper = 2 * top * div;
      aper = 2 * bper;
      bhi  = 2 * ((cmp >= top) ? top : cmp) * div;
    end else if (md == 1) begin
      bper = (top + 1) * div;
      aper = 2 * bper;
      bhi  = (((cmp >= top) ? top : cmp) + 1) * div;
    end else begin
      aper = 2 * (top + 1) * div;
      bper = aper;
      bhi  = 0;
    end
    start(md, sel, top, cmp);
    repeat (aper + 4 * div + 8) @(negedge clk);
    ahi_n = 0; bhi_n = 0; edges = 0;
    prev_a = wave_a;
    for (int i = 0; i < aper; i++) begin
      @(negedge clk);
      if (wave_a != prev_a) edges++;
      prev_a = wave_a;
      ahi_n += int'(wave_a);
      bhi_n += int'(wave_b);
    end
    check(edges == 2, {tag, " A edges per period"}, edges, 2);
    check(ahi_n == aper / 2, {tag, " A high time"}, ahi_n, aper / 2);
    check(bhi_n == (aper / bper) * bhi, {tag, " B high time"}, bhi_n, (aper / bper) * bhi);
  endtask

  task automatic run_len(input logic lvl, output int len);
    len = 0;
    while (wave_b == lvl && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int l0, l1, l2, l3, hi_cnt;
    rst_n = 1'b0; mode_sel = '0; pre_sel = '0; top_val = '0; cmpb_val = '0;

    // R2: stopped divider keeps both outputs low
    start(1, 0, 5, 3);
    hi_cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      hi_cnt += int'(wave_a) + int'(wave_b);
    end
    check(hi_cnt == 0, "R2 stopped divider", hi_cnt, 0);

    // R3: clear-at-TOP sweep, both codes
    for (int t = 0; t < 7; t++) run_cfg(0, 1, t, 3, "R3 clr");
    run_cfg(3, 1, 4, 2, "R3 alt code");
    run_cfg(0, 2, 3, 1, "R3 clr div8");

    // R4 R5: fast PWM sweep including CMP = TOP and CMP > TOP
    for (int t = 1; t < 7; t++)
      for (int c = 0; c < 8; c++) run_cfg(1, 1, t, c, "R4 R5 fast");

    // R6 R7: phase-correct sweep
    for (int t = 1; t < 7; t++)
      for (int c = 0; c < 8; c++) run_cfg(2, 1, t, c, "R6 R7 phase");

    // R2: every divider ratio
    for (int s = 1; s < 8; s++) run_cfg(1, s, 1, 0, "R2 divider");

    // R7: worked example
    run_cfg(2, 4, 180, 50, "R7 example");

    // R8: update mid-period lands at the next wrap
    start(1, 1, 9, 3);
    repeat (40) @(negedge clk);
    while (wave_b != 1'b0) @(negedge clk);
    while (wave_b != 1'b1) @(negedge clk);
    top_val  = 8'd14;
    cmpb_val = 8'd7;
    run_len(1'b1, l0);
    run_len(1'b0, l1);
    run_len(1'b1, l2);
    run_len(1'b0, l3);
    check(l0 == 4, "R8 old high run", l0, 4);
    check(l1 == 6, "R8 old low run", l1, 6);
    check(l2 == 8, "R8 new high run", l2, 8);
    check(l3 == 7, "R8 new low run", l3, 7);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule